// File: doc/BRIEF.md
# Address-Routing Memory Access Translator

This block sits on a processor's memory request port and sends each request to one of three targets: an instruction RAM, a data RAM, or an AHB-Lite system bus. Only the request address, the access kind (instruction fetch or data access) and the access size choose the target. The block returns one response per accepted request, carrying read data and an error flag.

Each access kind has its own policy for addresses that fall outside a target. A fetch outside the code range ends with an error. A data access that lands in the reserved data window beyond the implemented data RAM ends quietly, with no error and meaningless read data. A data access that matches neither RAM nor the window goes to the system bus, and a slave error there comes back as an error. Byte, halfword and word accesses are supported. The byte enables and the replicated write data are derived from the low address bits. Only one bus transfer may be in flight at a time, so the request port stalls while it completes.

The RAM paths answer in the cycle after acceptance with no wait states. The bus path runs one NONSEQ address phase and then a data phase that stretches while the slave holds HREADY low.

Top module: `mem_route_xlat`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, htrans is IDLE (2'b00), and iram_en and dram_en are 0.
- R2: A fetch whose address lies in [IRAM_BASE, IRAM_BASE+IRAM_SIZE) asserts iram_en in the accepting cycle, with iram_addr = (addr-IRAM_BASE)>>2. In the next cycle the block gives rsp_valid=1, rsp_err=0 and rsp_rdata equal to iram_rdata.
- R3: A fetch outside the code range touches no target. In the next cycle the block gives rsp_valid=1 and rsp_err=1.
- R4: A data access in [DRAM_BASE, DRAM_BASE+DRAM_SIZE) asserts dram_en in the accepting cycle, with dram_we equal to the direction and dram_addr = (addr-DRAM_BASE)>>2. In the next cycle the block gives rsp_valid=1, rsp_err=0 and rsp_rdata equal to dram_rdata.
- R5: A data access in [DWIN_BASE, DWIN_LAST] that is outside the data RAM touches no target, and a store there is dropped. In the next cycle the block gives rsp_valid=1 and rsp_err=0; the read data has no defined value.
- R6: Any other data address goes to the bus. In the cycle after acceptance, htrans is NONSEQ (2'b10), with haddr equal to the address, hsize equal to the size code and hwrite equal to the direction. The transfer lasts one beat, and htrans is IDLE in the data phase.
- R7: The size code is 0 for a byte, 1 for a halfword and 2 for a word. Byte enable bit i is set for a byte when addr[1:0]=i, for a halfword when addr[1]=i[1], and always for a word. Write data is the low byte replicated 4 times, the low halfword replicated twice, or the full word.
- R8: A halfword with addr[0]=1, a word with addr[1:0]≠0, or the size code 3 touches no target. In the next cycle the block gives rsp_valid=1 and rsp_err=1.
- R9: req_ready is 0 from the cycle after a bus request is accepted until the bus response cycle, in which req_ready is 1 again. A request held during that time is not accepted.
- R10: hwdata is driven in the data phase, and the transfer waits while hready is 0. In the cycle after the data phase ends with hready=1, rsp_valid=1, rsp_rdata equals the sampled hrdata and rsp_err equals the sampled hresp.
- R11: Every accepted request produces exactly one rsp_valid pulse of one cycle, and rsp_valid is 0 between requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| req_write | input | 1 | 1 = store (data accesses only) |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Error flag for the response |
| rsp_rdata | output | 32 | Read data word |
| iram_en | output | 1 | Instruction RAM read strobe |
| iram_addr | output | IRAM_AW | Instruction RAM word index |
| iram_rdata | input | 32 | Instruction RAM data, one cycle after strobe |
| dram_en | output | 1 | Data RAM strobe |
| dram_we | output | 1 | Data RAM write |
| dram_be | output | 4 | Data RAM byte enables |
| dram_addr | output | DRAM_AW | Data RAM word index |
| dram_wdata | output | 32 | Data RAM lane-replicated write data |
| dram_rdata | input | 32 | Data RAM data, one cycle after strobe |
| haddr | output | 32 | Bus address |
| htrans | output | 2 | Bus transfer type |
| hsize | output | 3 | Bus transfer size |
| hwrite | output | 1 | Bus direction |
| hwdata | output | 32 | Bus write data |
| hrdata | input | 32 | Bus read data |
| hready | input | 1 | Bus transfer done |
| hresp | input | 1 | Bus slave error |

## Verification
A wrong route decision shows up in the accepting cycle. The wrong RAM strobe rises, or NONSEQ appears one cycle later, and the error flag differs in the response that follows. A bus sequencer stuck in a phase or leaving it too early shows up as req_ready held low, as a second NONSEQ beat, or as a response that arrives before hready rises or never arrives. The stall check with a held request exposes any case where a request is accepted while a transfer is still in flight.

// File: rtl/xlat_pkg.sv
// Shared types for the address-routing translator.
// Assumes a 32-bit byte-addressed request port.
package xlat_pkg;
    typedef enum logic [1:0] {
        TGT_IRAM = 2'd0,
        TGT_DRAM = 2'd1,
        TGT_AHB  = 2'd2,
        TGT_NONE = 2'd3
    } route_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } size_e;

    typedef enum logic [1:0] {
        BUS_IDLE = 2'd0,
        BUS_ADDR = 2'd1,
        BUS_DATA = 2'd2
    } bus_st_e;

    localparam logic [1:0] HTRANS_IDLE   = 2'b00;
    localparam logic [1:0] HTRANS_NONSEQ = 2'b10;
endpackage

// File: rtl/xlat_lanes.sv
// Byte-lane unit: derives byte enables, replicated write data and the
// misalignment flag from the size code and the low address bits.
// Assumes a little-endian 32-bit bus with 4 byte lanes.
module xlat_lanes
    import xlat_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [1:0]         size,
    input  logic [1:0]         addr_lo,
    input  logic [8*LANES-1:0] wdata,
    output logic [LANES-1:0]   be,
    output logic [8*LANES-1:0] wdata_rep,
    output logic               misaligned
);
    // one enable per lane, selected by size and the address offset
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [1:0] IDX = 2'(i);
        assign be[i] = (size == SZ_WORD)
                     | ((size == SZ_HALF) && (addr_lo[1] == IDX[1]))
                     | ((size == SZ_BYTE) && (addr_lo == IDX));
    end

    // replicate the right-aligned store data onto every lane
    always_comb begin
        case (size)
            SZ_BYTE: wdata_rep = {LANES{wdata[7:0]}};
            SZ_HALF: wdata_rep = {(LANES/2){wdata[15:0]}};
            default: wdata_rep = wdata;
        endcase
    end

    // alignment rule: halfwords even, words on 4-byte boundaries, code 3 invalid
    always_comb begin
        case (size)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = addr_lo[0];
            SZ_WORD: misaligned = |addr_lo;
            default: misaligned = 1'b1;
        endcase
    end
endmodule

// File: rtl/xlat_decode.sv
// Address decoder: picks the target of a request and its error policy.
// Fetches may only reach the code RAM. Data accesses reach the data RAM,
// complete silently in the reserved data window, or fall through to the bus.
// Assumes the ranges do not overlap.
module xlat_decode
    import xlat_pkg::*;
#(
    parameter logic [31:0] IRAM_BASE = 32'hBFC0_0000,
    parameter logic [31:0] IRAM_SIZE = 32'h0001_0000,
    parameter logic [31:0] DRAM_BASE = 32'hBFD0_0000,
    parameter logic [31:0] DRAM_SIZE = 32'h0001_8000,
    parameter logic [31:0] DWIN_BASE = 32'hBFD1_8000,
    parameter logic [31:0] DWIN_LAST = 32'hBFFF_FFFF
) (
    input  logic        fetch,
    input  logic [31:0] addr,
    input  logic        misaligned,
    output route_e      route,
    output logic        fail
);
    localparam logic [31:0] DWIN_SPAN = DWIN_LAST - DWIN_BASE;

    logic in_iram, in_dram, in_win;

    // unsigned offset compare covers both range ends at once
    always_comb begin
        in_iram = (addr - IRAM_BASE) < IRAM_SIZE;
        in_dram = (addr - DRAM_BASE) < DRAM_SIZE;
        in_win  = (addr - DWIN_BASE) <= DWIN_SPAN;
    end

    // route choice and the per-kind out-of-range policy
    always_comb begin
        route = TGT_NONE;
        fail  = 1'b0;
        if (misaligned) begin
            fail = 1'b1;
        end else if (fetch) begin
            if (in_iram) route = TGT_IRAM;
            else         fail  = 1'b1;
        end else if (in_dram) begin
            route = TGT_DRAM;
        end else if (!in_win) begin
            route = TGT_AHB;
        end
    end
endmodule

// File: rtl/xlat_ahb_master.sv
// Single-transfer AHB-Lite master. It captures a request on start, drives
// one NONSEQ address phase, then a data phase that holds until hready.
// Assumes start is only raised while busy is low.
module xlat_ahb_master
    import xlat_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] addr,
    input  logic [1:0]    size,
    input  logic          write,
    input  logic [DW-1:0] wdata,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rd_data,
    output logic          rd_err,
    output logic [AW-1:0] haddr,
    output logic [1:0]    htrans,
    output logic [2:0]    hsize,
    output logic          hwrite,
    output logic [DW-1:0] hwdata,
    input  logic [DW-1:0] hrdata,
    input  logic          hready,
    input  logic          hresp
);
    bus_st_e       st;
    logic [AW-1:0] addr_q;
    logic [1:0]    size_q;
    logic          write_q;
    logic [DW-1:0] wdata_q;

    // phase sequencer and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= BUS_IDLE;
            addr_q  <= '0;
            size_q  <= '0;
            write_q <= 1'b0;
            wdata_q <= '0;
        end else begin
            case (st)
                BUS_IDLE: if (start) begin
                    st      <= BUS_ADDR;
                    addr_q  <= addr;
                    size_q  <= size;
                    write_q <= write;
                    wdata_q <= wdata;
                end
                BUS_ADDR: if (hready) st <= BUS_DATA;
                BUS_DATA: if (hready) st <= BUS_IDLE;
                default:  st <= BUS_IDLE;
            endcase
        end
    end

    // bus outputs and completion strobe
    always_comb begin
        htrans  = (st == BUS_ADDR) ? HTRANS_NONSEQ : HTRANS_IDLE;
        haddr   = addr_q;
        hsize   = {1'b0, size_q};
        hwrite  = write_q;
        hwdata  = wdata_q;
        busy    = (st != BUS_IDLE);
        done    = (st == BUS_DATA) && hready;
        rd_data = hrdata;
        rd_err  = hresp;
    end
endmodule

// File: rtl/mem_route_xlat.sv
// Top of the address-routing translator. It accepts one request per cycle
// unless a bus transfer is in flight, steers it to the code RAM, the data RAM
// or the bus, and returns one registered response per request.
// Assumes the RAMs return read data the cycle after their strobe.
module mem_route_xlat
    import xlat_pkg::*;
#(
    parameter logic [31:0] IRAM_BASE = 32'hBFC0_0000,
    parameter logic [31:0] IRAM_SIZE = 32'h0001_0000,
    parameter logic [31:0] DRAM_BASE = 32'hBFD0_0000,
    parameter logic [31:0] DRAM_SIZE = 32'h0001_8000,
    parameter logic [31:0] DWIN_BASE = 32'hBFD1_8000,
    parameter logic [31:0] DWIN_LAST = 32'hBFFF_FFFF,
    parameter int          IRAM_AW   = $clog2(IRAM_SIZE) - 2,
    parameter int          DRAM_AW   = $clog2(DRAM_SIZE) - 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_fetch,
    input  logic               req_write,
    input  logic [1:0]         req_size,
    input  logic [31:0]        req_addr,
    input  logic [31:0]        req_wdata,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic [31:0]        rsp_rdata,
    output logic               iram_en,
    output logic [IRAM_AW-1:0] iram_addr,
    input  logic [31:0]        iram_rdata,
    output logic               dram_en,
    output logic               dram_we,
    output logic [3:0]         dram_be,
    output logic [DRAM_AW-1:0] dram_addr,
    output logic [31:0]        dram_wdata,
    input  logic [31:0]        dram_rdata,
    output logic [31:0]        haddr,
    output logic [1:0]         htrans,
    output logic [2:0]         hsize,
    output logic               hwrite,
    output logic [31:0]        hwdata,
    input  logic [31:0]        hrdata,
    input  logic               hready,
    input  logic               hresp
);
    logic [3:0]  lane_be;
    logic [31:0] lane_wdata;
    logic        misaligned;
    route_e      route;
    logic        route_fail;
    logic        accept;
    logic        bus_start, bus_busy, bus_done, bus_err;
    logic [31:0] bus_rdata;
    logic        rsp_valid_q, rsp_err_q;
    route_e      rsp_src_q;
    logic [31:0] bus_rdata_q;

    xlat_lanes #(.LANES(4)) u_lanes (
        .size       (req_size),
        .addr_lo    (req_addr[1:0]),
        .wdata      (req_wdata),
        .be         (lane_be),
        .wdata_rep  (lane_wdata),
        .misaligned (misaligned)
    );

    xlat_decode #(
        .IRAM_BASE (IRAM_BASE), .IRAM_SIZE (IRAM_SIZE),
        .DRAM_BASE (DRAM_BASE), .DRAM_SIZE (DRAM_SIZE),
        .DWIN_BASE (DWIN_BASE), .DWIN_LAST (DWIN_LAST)
    ) u_dec (
        .fetch      (req_fetch),
        .addr       (req_addr),
        .misaligned (misaligned),
        .route      (route),
        .fail       (route_fail)
    );

    xlat_ahb_master #(.DW(32), .AW(32)) u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (bus_start),
        .addr    (req_addr),
        .size    (req_size),
        .write   (req_write),
        .wdata   (lane_wdata),
        .busy    (bus_busy),
        .done    (bus_done),
        .rd_data (bus_rdata),
        .rd_err  (bus_err),
        .haddr   (haddr),
        .htrans  (htrans),
        .hsize   (hsize),
        .hwrite  (hwrite),
        .hwdata  (hwdata),
        .hrdata  (hrdata),
        .hready  (hready),
        .hresp   (hresp)
    );

    // acceptance and target strobes for the current request
    always_comb begin
        req_ready  = !bus_busy;
        accept     = req_valid && req_ready;
        iram_en    = accept && (route == TGT_IRAM);
        iram_addr  = IRAM_AW'((req_addr - IRAM_BASE) >> 2);
        dram_en    = accept && (route == TGT_DRAM);
        dram_we    = req_write;
        dram_be    = lane_be;
        dram_addr  = DRAM_AW'((req_addr - DRAM_BASE) >> 2);
        dram_wdata = lane_wdata;
        bus_start  = accept && (route == TGT_AHB);
    end

    // response register: one pulse per accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_err_q   <= 1'b0;
            rsp_src_q   <= TGT_NONE;
            bus_rdata_q <= '0;
        end else begin
            rsp_valid_q <= (accept && (route != TGT_AHB)) || bus_done;
            if (accept && (route != TGT_AHB)) begin
                rsp_src_q <= route;
                rsp_err_q <= route_fail;
            end else if (bus_done) begin
                rsp_src_q   <= TGT_AHB;
                rsp_err_q   <= bus_err;
                bus_rdata_q <= bus_rdata;
            end
        end
    end

    // read data return from the source of the response
    always_comb begin
        rsp_valid = rsp_valid_q;
        rsp_err   = rsp_err_q;
        case (rsp_src_q)
            TGT_IRAM: rsp_rdata = iram_rdata;
            TGT_DRAM: rsp_rdata = dram_rdata;
            TGT_AHB:  rsp_rdata = bus_rdata_q;
            default:  rsp_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mem_route_xlat_chk.sv
// Protocol checker for the translator, attached to every instance by bind.
// Assumes it sees the top-level ports only.
module mem_route_xlat_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        iram_en,
    input logic        dram_en,
    input logic [3:0]  dram_be,
    input logic [31:0] haddr,
    input logic [1:0]  htrans,
    input logic        hready,
    input logic        rsp_valid,
    input logic        rsp_err
);
    // at most one target is started in any cycle
    p_one_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({iram_en, dram_en, htrans == 2'b10}));

    // code RAM answers the next cycle without error
    p_iram_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        iram_en |=> (rsp_valid && !rsp_err));

    // data RAM answers the next cycle without error
    p_dram_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dram_en |=> (rsp_valid && !rsp_err));

    // a RAM strobe only follows an accepted request
    p_strobe_accepted_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (iram_en || dram_en) |-> (req_valid && req_ready));

    // every data RAM access enables at least one lane
    p_lanes_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dram_en |-> (dram_be != 4'b0000));

    // no new request is taken while a transfer occupies the bus
    p_stall_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans != 2'b00) |-> !req_ready);

    // the address phase is a single beat once hready is high
    p_single_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == 2'b10 && hready) |=> (htrans == 2'b00));

    // a stretched address phase holds its address
    p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == 2'b10 && !hready) |=> (htrans == 2'b10 && $stable(haddr)));
endmodule

bind mem_route_xlat mem_route_xlat_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .iram_en   (iram_en),
    .dram_en   (dram_en),
    .dram_be   (dram_be),
    .haddr     (haddr),
    .htrans    (htrans),
    .hready    (hready),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err)
);

// File: tb/tb_mem_route_xlat.sv
module tb_mem_route_xlat;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] IR_BASE = 32'hBFC0_0000;
    localparam logic [31:0] DR_BASE = 32'hBFD0_0000;
    localparam logic [31:0] IR_PAT  = 32'h1111_0000;
    localparam logic [31:0] DR_PAT  = 32'h2222_0000;
    localparam logic [31:0] BUS_PAT = 32'h3333_0000;
    localparam logic [1:0] T_IR = 2'd0, T_DR = 2'd1, T_BUS = 2'd2, T_NO = 2'd3;

    typedef struct packed {
        logic        fetch;
        logic        write;
        logic [1:0]  size;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [1:0]  tgt;
        logic        err;
        logic [3:0]  be;
        logic [31:0] wexp;
        logic [3:0]  waits;
        logic        slverr;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b1, 1'b0, 2'd2, 32'hBFC0_0010, 32'h0, T_IR,  1'b0, 4'hF, 32'h0,        4'd0, 1'b0},
        '{1'b1, 1'b0, 2'd2, 32'hBFC0_FFFC, 32'h0, T_IR,  1'b0, 4'hF, 32'h0,        4'd0, 1'b0},
        '{1'b1, 1'b0, 2'd2, 32'hBFC1_0000, 32'h0, T_NO,  1'b1, 4'h0, 32'h0,        4'd0, 1'b0},
        '{1'b1, 1'b0, 2'd2, 32'hBFBF_FFFC, 32'h0, T_NO,  1'b1, 4'h0, 32'h0,        4'd0, 1'b0},
        '{1'b0, 1'b0, 2'd0, 32'hBFD0_0003, 32'h0, T_DR,  1'b0, 4'h8, 32'h0,        4'd0, 1'b0},
        '{1'b0, 1'b1, 2'd1, 32'hBFD0_0102, 32'h0000_BEEF, T_DR, 1'b0, 4'hC, 32'hBEEF_BEEF, 4'd0, 1'b0},
        '{1'b0, 1'b1, 2'd2, 32'hBFD1_7FFC, 32'hCAFE_F00D, T_DR, 1'b0, 4'hF, 32'hCAFE_F00D, 4'd0, 1'b0},
        '{1'b0, 1'b1, 2'd0, 32'hBFD0_0002, 32'h0000_0055, T_DR, 1'b0, 4'h4, 32'h5555_5555, 4'd0, 1'b0},
        '{1'b0, 1'b0, 2'd2, 32'hBFD1_8000, 32'h0, T_NO,  1'b0, 4'h0, 32'h0,        4'd0, 1'b0},
        '{1'b0, 1'b1, 2'd0, 32'hBFFF_FFFF, 32'hAA, T_NO, 1'b0, 4'h0, 32'h0,        4'd0, 1'b0},
        '{1'b0, 1'b0, 2'd0, 32'hA000_0001, 32'h0, T_BUS, 1'b0, 4'h0, 32'h0,        4'd0, 1'b0},
        '{1'b0, 1'b1, 2'd1, 32'hA000_0006, 32'h0000_1234, T_BUS, 1'b0, 4'h0, 32'h1234_1234, 4'd2, 1'b0},
        '{1'b0, 1'b0, 2'd2, 32'hA000_0008, 32'h0, T_BUS, 1'b0, 4'h0, 32'h0,        4'd3, 1'b0},
        '{1'b0, 1'b0, 2'd2, 32'hAE00_0000, 32'h0, T_BUS, 1'b1, 4'h0, 32'h0,        4'd2, 1'b1},
        '{1'b0, 1'b0, 2'd1, 32'hBFD0_0001, 32'h0, T_NO,  1'b1, 4'h0, 32'h0,        4'd0, 1'b0},
        '{1'b0, 1'b1, 2'd2, 32'hA000_0002, 32'h5, T_NO,  1'b1, 4'h0, 32'h0,        4'd0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_fetch = 1'b0, req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_addr = 32'h0, req_wdata = 32'h0;
    logic        req_ready, rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        iram_en, dram_en, dram_we;
    logic [13:0] iram_addr;
    logic [14:0] dram_addr;
    logic [3:0]  dram_be;
    logic [31:0] dram_wdata;
    logic [31:0] iram_rdata = 32'h0, dram_rdata = 32'h0, hrdata = 32'h0;
    logic [31:0] haddr, hwdata;
    logic [1:0]  htrans;
    logic [2:0]  hsize;
    logic        hwrite;
    logic        hready = 1'b1, hresp = 1'b0;

    int n_checks = 0;
    int n_err = 0;
    logic finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_route_xlat dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_fetch(req_fetch),
        .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .iram_en(iram_en), .iram_addr(iram_addr),
        .iram_rdata(iram_rdata), .dram_en(dram_en), .dram_we(dram_we),
        .dram_be(dram_be), .dram_addr(dram_addr), .dram_wdata(dram_wdata),
        .dram_rdata(dram_rdata), .haddr(haddr), .htrans(htrans), .hsize(hsize),
        .hwrite(hwrite), .hwdata(hwdata), .hrdata(hrdata), .hready(hready),
        .hresp(hresp)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    endtask

    // one vector: drive, check strobes, run bus handshake, check response
    task automatic run_vec(input vec_t v, input int idx);
        string tg;
        if (v.tgt == T_IR)       tg = "R2";
        else if (v.tgt == T_DR)  tg = "R4";
        else if (v.tgt == T_BUS) tg = "R6";
        else if (v.fetch)        tg = "R3";
        else if (v.err)          tg = "R8";
        else                     tg = "R5";
        @(negedge clk);
        req_valid = 1'b1; req_fetch = v.fetch; req_write = v.write;
        req_size = v.size; req_addr = v.addr; req_wdata = v.wdata;
        iram_rdata = IR_PAT ^ 32'(idx); dram_rdata = DR_PAT ^ 32'(idx);
        #1;
        check({tg, " ready R9"}, 32'(req_ready), 32'd1);
        check({tg, " iram_en"}, 32'(iram_en), 32'(v.tgt == T_IR));
        check({tg, " dram_en"}, 32'(dram_en), 32'(v.tgt == T_DR));
        if (v.tgt == T_IR)
            check("R2 iram_addr", 32'(iram_addr), (v.addr - IR_BASE) >> 2);
        if (v.tgt == T_DR) begin
            check("R4 dram_addr", 32'(dram_addr), (v.addr - DR_BASE) >> 2);
            check("R4 dram_we", 32'(dram_we), 32'(v.write));
            check("R7 dram_be", 32'(dram_be), 32'(v.be));
            if (v.write) check("R7 dram_wdata", dram_wdata, v.wexp);
        end
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        if (v.tgt != T_BUS) begin
            check({tg, " rsp_valid R11"}, 32'(rsp_valid), 32'd1);
            check({tg, " rsp_err"}, 32'(rsp_err), 32'(v.err));
            check({tg, " no bus"}, 32'(htrans), 32'd0);
            if (v.tgt == T_IR) check("R2 rdata", rsp_rdata, IR_PAT ^ 32'(idx));
            if (v.tgt == T_DR) check("R4 rdata", rsp_rdata, DR_PAT ^ 32'(idx));
        end else begin
            check("R6 htrans", 32'(htrans), 32'h2);
            check("R6 haddr", haddr, v.addr);
            check("R6 hsize", 32'(hsize), 32'(v.size));
            check("R6 hwrite", 32'(hwrite), 32'(v.write));
            check("R9 stall", 32'(req_ready), 32'd0);
            check("R11 no early rsp", 32'(rsp_valid), 32'd0);
            @(negedge clk);
            #1;
            check("R6 single beat", 32'(htrans), 32'd0);
            if (v.write) check("R10 hwdata", hwdata, v.wexp);
            for (int w = 0; w < int'(v.waits); w++) begin
                hready = 1'b0; hresp = 1'b0;
                @(negedge clk);
                #1;
                check("R10 wait no rsp", 32'(rsp_valid), 32'd0);
                check("R9 wait stall", 32'(req_ready), 32'd0);
            end
            if (v.slverr) begin
                hready = 1'b0; hresp = 1'b1;
                @(negedge clk);
            end
            hready = 1'b1; hresp = v.slverr; hrdata = BUS_PAT ^ 32'(idx);
            @(negedge clk);
            hresp = 1'b0; hrdata = 32'h0;
            #1;
            check("R10 rsp_valid", 32'(rsp_valid), 32'd1);
            check("R10 rsp_err", 32'(rsp_err), 32'(v.err));
            if (!v.err) check("R10 rdata", rsp_rdata, BUS_PAT ^ 32'(idx));
            check("R9 ready again", 32'(req_ready), 32'd1);
        end
        @(negedge clk);
        #1;
        check("R11 single pulse", 32'(rsp_valid), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 ready", 32'(req_ready), 32'd1);
        check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        check("R1 htrans", 32'(htrans), 32'd0);
        check("R1 strobes", {30'd0, iram_en, dram_en}, 32'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // R9: a code fetch held during a bus transfer waits for it
        @(negedge clk);
        req_valid = 1'b1; req_fetch = 1'b0; req_write = 1'b0;
        req_size = 2'd2; req_addr = 32'hA000_0010;
        @(negedge clk);
        req_fetch = 1'b1; req_addr = 32'hBFC0_0020; iram_rdata = 32'h5A5A_0001;
        #1;
        check("R9 held not taken", 32'(iram_en), 32'd0);
        @(negedge clk);
        hready = 1'b0;
        #1;
        check("R9 held in data phase", 32'(iram_en), 32'd0);
        @(negedge clk);
        hready = 1'b1; hrdata = 32'h0BAD_F00D;
        @(negedge clk);
        #1;
        check("R10 bus rsp before fetch", 32'(rsp_valid), 32'd1);
        check("R10 bus rdata", rsp_rdata, 32'h0BAD_F00D);
        check("R9 fetch taken after rsp", 32'(iram_en), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check("R2 fetch rsp", 32'(rsp_valid), 32'd1);
        check("R2 fetch rdata", rsp_rdata, 32'h5A5A_0001);
        @(negedge clk);
        #1;
        check("R11 idle after", 32'(rsp_valid), 32'd0);

        report();
        finished = 1'b1;
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            report();
            $finish;
        end
    end
endmodule